// File: doc/BRIEF.md
# Inter-Core Mailbox Register Block

This block gives a cluster of processor cores a hardware path for short messages and wake-up requests. Every core owns a small set of 32-bit mailboxes. Any core may post into any mailbox by writing bits to that mailbox's set address. The written value is ORed into the stored word, so several senders can raise separate flag bits without a read-modify-write sequence. The owning core reads the mailbox through a second address, the clear alias. It acknowledges a message by writing ones back to that alias, which clears exactly those bits.

Each core also has a mailbox-enable register. A core's interrupt line is raised while at least one of its enabled mailboxes holds a nonzero word. This lets the receiver sleep instead of polling. The register bus is a plain single-cycle port carrying address, write strobe, write data and registered read data. Arbitration between cores happens upstream of this block.

Top module: `ipc_mailbox_regs`

## Requirements
- R1: After a synchronous reset every mailbox word and every enable register is 0, every `irq` bit is 0 and `rd_data` is 0.
- R2: A write to byte offset 0x80 + 0x10·c + 4·n (core c in 0..3, mailbox n in 0..3) ORs `req_wdata` into mailbox n of core c. Bits written as 0 keep their value.
- R3: A read of the clear alias at set offset + 0x40 (0xC0 + 0x10·c + 4·n) returns the full current contents of that mailbox.
- R4: A write to the clear alias clears each mailbox bit whose `req_wdata` bit is 1 and leaves every other bit unchanged.
- R5: A read of any set-region offset (0x80 to 0xBF) returns 0.
- R6: The enable register of core c sits at offset 0x50 + 4·c. Write-data bit n enables mailbox n of that core. A read returns the enables in bits 3:0 and zeros in bits 31:4.
- R7: `irq[c]` is 1 exactly when some mailbox n of core c is nonzero and its enable bit n is 1. The output is registered, so it changes one cycle after the clock edge that changed the mailbox or enable state.
- R8: Offsets outside the three regions, and offsets whose two low bits are not 00, read as 0. Writes to them change no mailbox and no enable register.
- R9: Read data appears on `rd_data` in the cycle after the read is accepted. After a cycle with no accepted read, `rd_data` is 0. A read followed at once by a write to the same mailbox returns the contents from before that write.
- R10: A write to one mailbox leaves the other fifteen mailboxes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, one cycle after the read |
| irq | output | 4 | Per-core interrupt, registered |

## Verification
Two functions can land in the same cycle: the registered return of a read, and the next accepted write to the same mailbox. The bench provokes this by issuing a clear-alias read and then, in the very next cycle, a set to that mailbox. While the write is being presented, `rd_data` must show the value from before the write. One cycle later `rd_data` must be 0, and a further read must show the newly ORed bit. A second overlap exists between a state change and the interrupt output. Here the bench checks that `irq` still shows the old condition in the cycle straight after a clear or enable write, and only shows the new condition one cycle later.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

  // Kind of register an address falls into.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_EN   = 2'd3
  } acc_kind_e;

  // Fixed map geometry (byte offsets).
  localparam int unsigned MAP_SET_BASE    = 32'h80;
  localparam int unsigned MAP_CORE_STRIDE = 32'h10;
  localparam int unsigned MAP_WORD_BYTES  = 32'h4;
  localparam int unsigned MAP_EN_BASE     = 32'h50;

endpackage

// File: rtl/ipc_mailbox_decode.sv
module ipc_mailbox_decode
  import ipc_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 4,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 4,
  parameter int CORE_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  mb_idx,
  output logic [CORE_W-1:0] en_core
);

  localparam int unsigned SPAN     = NUM_CORES * MAP_CORE_STRIDE;
  localparam int unsigned CLR_BASE = MAP_SET_BASE + SPAN;
  localparam int unsigned EN_END   = MAP_EN_BASE + NUM_CORES * MAP_WORD_BYTES;

  logic [31:0] a;
  logic [31:0] set_off;
  logic [31:0] clr_off;
  logic [31:0] set_slot;
  logic [31:0] clr_slot;

  always_comb begin
    a        = 32'(addr);
    set_off  = a - MAP_SET_BASE;
    clr_off  = a - CLR_BASE;
    set_slot = (set_off % MAP_CORE_STRIDE) / MAP_WORD_BYTES;
    clr_slot = (clr_off % MAP_CORE_STRIDE) / MAP_WORD_BYTES;
  end

  always_comb begin
    kind    = ACC_NONE;
    mb_idx  = '0;
    en_core = '0;
    if (a[1:0] == 2'b00) begin
      if (a >= MAP_SET_BASE && set_off < SPAN && set_slot < NUM_SLOTS) begin
        kind   = ACC_SET;
        mb_idx = IDX_W'((set_off / MAP_CORE_STRIDE) * NUM_SLOTS + set_slot);
      end else if (a >= CLR_BASE && clr_off < SPAN && clr_slot < NUM_SLOTS) begin
        kind   = ACC_CLR;
        mb_idx = IDX_W'((clr_off / MAP_CORE_STRIDE) * NUM_SLOTS + clr_slot);
      end else if (a >= MAP_EN_BASE && a < EN_END) begin
        kind    = ACC_EN;
        en_core = CORE_W'((a - MAP_EN_BASE) / MAP_WORD_BYTES);
      end
    end
  end

endmodule

// File: rtl/ipc_mailbox_cell.sv
module ipc_mailbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q
);

  // Set and clear never coincide: the bus carries one access per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (set_en) begin
      word_q <= word_q | wdata;
    end else if (clr_en) begin
      word_q <= word_q & ~wdata;
    end
  end

endmodule

// File: rtl/ipc_mailbox_irq.sv
module ipc_mailbox_irq #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en_wr,
  input  logic [NUM_SLOTS-1:0]        en_wdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] words,
  output logic [NUM_SLOTS-1:0]        en_q,
  output logic                        irq_q
);

  logic [NUM_SLOTS-1:0] pending;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pend
    assign pending[s] = en_q[s] && (|words[s*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      irq_q <= |pending;
    end
  end

endmodule

// File: rtl/ipc_mailbox_regs.sv
module ipc_mailbox_regs
  import ipc_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_CORES-1:0] irq
);

  localparam int TOTAL  = NUM_CORES * NUM_SLOTS;
  localparam int IDX_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  acc_kind_e               kind;
  logic [IDX_W-1:0]        mb_idx;
  logic [CORE_W-1:0]       en_core;
  logic                    wr_acc;
  logic                    rd_acc;
  logic [TOTAL*DATA_W-1:0] mbox_flat;
  logic [TOTAL-1:0]        en_flat;
  logic [DATA_W-1:0]       rd_next;

  assign wr_acc = req_valid && req_write;
  assign rd_acc = req_valid && !req_write;

  ipc_mailbox_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_CORES(NUM_CORES),
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_W    (IDX_W),
    .CORE_W   (CORE_W)
  ) u_decode (
    .addr   (req_addr),
    .kind   (kind),
    .mb_idx (mb_idx),
    .en_core(en_core)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int K = c * NUM_SLOTS + s;
      logic hit;
      assign hit = wr_acc && (mb_idx == IDX_W'(K));
      ipc_mailbox_cell #(.DATA_W(DATA_W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_en(hit && kind == ACC_SET),
        .clr_en(hit && kind == ACC_CLR),
        .wdata (req_wdata),
        .word_q(mbox_flat[K*DATA_W +: DATA_W])
      );
    end

    ipc_mailbox_irq #(
      .NUM_SLOTS(NUM_SLOTS),
      .DATA_W   (DATA_W)
    ) u_irq (
      .clk     (clk),
      .rst     (rst),
      .en_wr   (wr_acc && kind == ACC_EN && en_core == CORE_W'(c)),
      .en_wdata(req_wdata[NUM_SLOTS-1:0]),
      .words   (mbox_flat[c*NUM_SLOTS*DATA_W +: NUM_SLOTS*DATA_W]),
      .en_q    (en_flat[c*NUM_SLOTS +: NUM_SLOTS]),
      .irq_q   (irq[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_acc) begin
      case (kind)
        ACC_CLR: rd_next = mbox_flat[mb_idx*DATA_W +: DATA_W];
        ACC_EN:  rd_next[NUM_SLOTS-1:0] = en_flat[en_core*NUM_SLOTS +: NUM_SLOTS];
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/ipc_mailbox_checker.sv
module ipc_mailbox_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int NUM_SLOTS = 4
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  req_valid,
  input logic                                  req_write,
  input logic [ADDR_W-1:0]                     req_addr,
  input logic [DATA_W-1:0]                     req_wdata,
  input logic [DATA_W-1:0]                     rd_data,
  input logic [NUM_CORES-1:0]                  irq,
  input logic [NUM_CORES*NUM_SLOTS*DATA_W-1:0] mbox_flat,
  input logic [NUM_CORES*NUM_SLOTS-1:0]        en_flat
);

  localparam int TOTAL  = NUM_CORES * NUM_SLOTS;
  localparam int IDX_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int unsigned SET_LO = 32'h80;
  localparam int unsigned SET_HI = SET_LO + 16 * NUM_CORES;
  localparam int unsigned CLR_HI = SET_HI + 16 * NUM_CORES;
  localparam int unsigned EN_LO  = 32'h50;
  localparam int unsigned EN_HI  = EN_LO + 4 * NUM_CORES;

  logic [31:0]      a;
  logic             aligned;
  logic             in_set;
  logic             in_clr;
  logic             in_en;
  logic [IDX_W-1:0] set_k;
  logic [IDX_W-1:0] clr_k;

  always_comb begin
    a       = 32'(req_addr);
    aligned = (a[1:0] == 2'b00);
    in_set  = aligned && a >= SET_LO && a < SET_HI && ((a - SET_LO) % 16) / 4 < NUM_SLOTS;
    in_clr  = aligned && a >= SET_HI && a < CLR_HI && ((a - SET_HI) % 16) / 4 < NUM_SLOTS;
    in_en   = aligned && a >= EN_LO && a < EN_HI;
    set_k   = IDX_W'(((a - SET_LO) / 16) * NUM_SLOTS + ((a - SET_LO) % 16) / 4);
    clr_k   = IDX_W'(((a - SET_HI) / 16) * NUM_SLOTS + ((a - SET_HI) % 16) / 4);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == '0 && rd_data == '0)); // R1

  AST_SET_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && in_set) |=> (rd_data == '0)); // R5

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> (rd_data == '0)); // R9

  AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !in_set && !in_clr && !in_en)
      |=> ($stable(mbox_flat) && $stable(en_flat))); // R8

  for (genvar k = 0; k < TOTAL; k++) begin : g_mb
    AST_SET_ORS: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_write && in_set && set_k == IDX_W'(k))
        |=> ((mbox_flat[k*DATA_W +: DATA_W] & $past(req_wdata)) == $past(req_wdata))); // R2

    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_write && in_clr && clr_k == IDX_W'(k))
        |=> ((mbox_flat[k*DATA_W +: DATA_W] & $past(req_wdata)) == '0)); // R4
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> ($past(|mbox_flat[c*NUM_SLOTS*DATA_W +: NUM_SLOTS*DATA_W])
                  && $past(|en_flat[c*NUM_SLOTS +: NUM_SLOTS]))); // R7
  end

endmodule

bind ipc_mailbox_regs ipc_mailbox_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_CORES(NUM_CORES),
  .NUM_SLOTS(NUM_SLOTS)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rd_data  (rd_data),
  .irq      (irq),
  .mbox_flat(mbox_flat),
  .en_flat  (en_flat)
);

// File: tb/test_ipc_mailbox_regs.sv
module test_ipc_mailbox_regs;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] rd_data;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl_mb [NC*NS];
  logic [NS-1:0] mdl_en [NC];

  always #10 clk = ~clk;

  ipc_mailbox_regs i_ipc_mailbox_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [7:0] set_addr(int c, int s);
    return 8'(32'h80 + 16 * c + 4 * s);
  endfunction

  function automatic logic [7:0] clr_addr(int c, int s);
    return 8'(32'hC0 + 16 * c + 4 * s);
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (mdl_en[c][s] && mdl_mb[c*NS+s] != '0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic post(int c, int s, logic [DW-1:0] v);
    bus_write(set_addr(c, s), v);
    mdl_mb[c*NS+s] = mdl_mb[c*NS+s] | v;
  endtask

  task automatic ack(int c, int s, logic [DW-1:0] v);
    bus_write(clr_addr(c, s), v);
    mdl_mb[c*NS+s] = mdl_mb[c*NS+s] & ~v;
  endtask

  task automatic check_all_mailboxes(string req);
    logic [DW-1:0] d;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) begin
        bus_read(clr_addr(c, s), d);
        check(req, d, mdl_mb[c*NS+s]);
      end
  endtask

  task automatic check_enables(string req);
    logic [DW-1:0] d;
    for (int c = 0; c < NC; c++) begin
      bus_read(8'(32'h50 + 4 * c), d);
      check(req, d, DW'(mdl_en[c]));
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    check("R1 irq", DW'(irq), '0);
    check("R1 rd_data", rd_data, '0);
    check_all_mailboxes("R1 mailbox");
    check_enables("R1 enable");
  endtask

  // R2 R3 R10: OR accumulation, read through the clear alias, isolation
  task automatic t_set_or();
    logic [DW-1:0] d;
    post(0, 3, 32'h0000_00F0);
    post(0, 3, 32'h0000_0F03);
    bus_read(8'hCC, d);
    check("R2 R3 or-accumulate c0m3", d, 32'h0000_0FF3);
    post(1, 3, 32'hA5A5_0000);
    post(1, 3, 32'h0000_0000);
    bus_read(8'hDC, d);
    check("R2 zero write keeps c1m3", d, 32'hA5A5_0000);
    post(3, 0, 32'h8000_0001);
    check_all_mailboxes("R10 isolation");
  endtask

  // R5: set region reads zero
  task automatic t_set_reads_zero();
    logic [DW-1:0] d;
    bus_read(8'h8C, d);
    check("R5 set read c0m3", d, '0);
    bus_read(8'hB0, d);
    check("R5 set read c3m0", d, '0);
  endtask

  // R4: partial clear
  task automatic t_partial_clear();
    logic [DW-1:0] d;
    ack(0, 3, 32'h0000_00F0);
    bus_read(8'hCC, d);
    check("R4 partial clear", d, 32'h0000_0F03);
    ack(3, 0, 32'h0000_0001);
    bus_read(8'hF0, d);
    check("R4 clear low bit", d, 32'h8000_0000);
  endtask

  // R6 R7: enables and interrupt timing
  task automatic t_enable_irq();
    logic [DW-1:0] d;
    bus_write(8'h54, 32'hFFFF_FFFF);
    mdl_en[1] = 4'hF;
    bus_read(8'h54, d);
    check("R6 enable readback", d, 32'h0000_000F);
    check("R7 irq core1 raised", DW'(irq), DW'(exp_irq()));
    ack(1, 3, 32'hFFFF_FFFF);
    check("R7 irq still old one cycle", DW'(irq[1]), 1);
    @(negedge clk);
    check("R7 irq core1 dropped", DW'(irq), DW'(exp_irq()));
    bus_write(8'h58, 32'h0000_0001);
    mdl_en[2] = 4'h1;
    post(2, 1, 32'h0000_0040);
    @(negedge clk);
    check("R7 disabled mailbox no irq", DW'(irq[2]), 0);
    post(2, 0, 32'h0000_0002);
    @(negedge clk);
    check("R7 enabled mailbox irq", DW'(irq), DW'(exp_irq()));
    bus_write(8'h58, 32'hFFFF_FFF0);
    mdl_en[2] = 4'h0;
    check("R7 irq holds after enable write", DW'(irq[2]), 1);
    @(negedge clk);
    check("R7 irq off after disable", DW'(irq), DW'(exp_irq()));
    check_enables("R6 enable map");
  endtask

  // R8: unmapped and misaligned offsets
  task automatic t_unmapped();
    logic [DW-1:0] d;
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h44, 32'hFFFF_FFFF);
    bus_write(8'h60, 32'hFFFF_FFFF);
    bus_write(8'h8D, 32'hFFFF_FFFF);
    bus_write(8'hCE, 32'hFFFF_FFFF);
    bus_write(8'h51, 32'hFFFF_FFFF);
    bus_read(8'h60, d);
    check("R8 unmapped read", d, '0);
    bus_read(8'hCD, d);
    check("R8 misaligned read", d, '0);
    check_all_mailboxes("R8 mailboxes untouched");
    check_enables("R8 enables untouched");
  endtask

  // R9: read return coinciding with a write to the same mailbox
  task automatic t_collision();
    logic [DW-1:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'hCC;
    @(negedge clk);
    check("R9 read-before-write value", rd_data, mdl_mb[3]);
    req_write = 1'b1; req_addr = 8'h8C; req_wdata = 32'h0001_0000;
    mdl_mb[3] = mdl_mb[3] | 32'h0001_0000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R9 zero after write cycle", rd_data, '0);
    bus_read(8'hCC, d);
    check("R9 read sees new bit", d, mdl_mb[3]);
  endtask

  initial begin
    for (int k = 0; k < NC*NS; k++) mdl_mb[k] = '0;
    for (int c = 0; c < NC; c++) mdl_en[c] = '0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_or();
    t_set_reads_zero();
    t_partial_clear();
    t_enable_irq();
    t_unmapped();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule